// File: doc/BRIEF.md
# Latched interrupt request controller

This block turns a set of event strobes into one active-low interrupt request for an attached microcontroller. Three status-bit strobes, a resume strobe, a bus-reset strobe and a wake level feed a pending latch. The latch keeps one cause bit per source, so the source of each request is known. While the serial mode select is high, the request level is placed on the shared serial output pin. While it is low, the pin carries the bit from the data shifter, and this block only affects its own request.

The controller reads the status register to clear the request. A read is bracketed by a start strobe and a done strobe. The main latch is cleared as soon as the read opens. Events that arrive while the read is open go into a shadow register. When the read closes, the shadow contents move into the main latch, so no event is lost and each one causes a fresh request after that read. The wake level only counts while the configuration shows a stop state, which means at least one bit of the stop configuration field is set.

Top module: `irq_latch_ctl`

## Requirements
- R1: After reset, irq_n is high, cause is all zero and no read is open.
- R2: A strobe on ev_stat[i] while no read is open sets cause[i] on the next clock edge and drives irq_n low. Bit i of ev_stat stands for status bit i+1. Both stay until a read opens.
- R3: A strobe on ev_resume sets cause[3] and a strobe on ev_bus_reset sets cause[4], each with irq_n low on the next edge. These positions apply with the default of three status bits.
- R4: A high wake_req sets cause[5] only while stop_cfg is non-zero. When stop_cfg is zero, wake_req does not change cause or irq_n.
- R5: A clock edge with rd_start high, or with a read open and rd_done low, leaves cause all zero and irq_n high after that edge.
- R6: Events seen during an open read, including the cycles of rd_start and rd_done, do not show on cause or irq_n until the read closes. On the rd_done edge they are all loaded into cause, and irq_n goes low on that edge if any were seen.
- R7: When ser_sel is high, ser_out equals irq_n. When ser_sel is low, ser_out equals shift_bit.
- R8: rd_done with no open read and no rd_start has no effect: events still accumulate in cause as in R2.
- R9: rd_start and rd_done in the same cycle perform a complete read. cause becomes exactly the events of that cycle.
- R10: rd_start while a read is already open keeps the read open and keeps the events already deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_stat | input | 3 | One-cycle strobes, one per interrupt-capable status bit |
| ev_resume | input | 1 | One-cycle resume strobe |
| ev_bus_reset | input | 1 | One-cycle bus reset strobe |
| wake_req | input | 1 | Wake level |
| stop_cfg | input | 2 | Stop-state configuration bits; non-zero means stop state |
| rd_start | input | 1 | Status read begins |
| rd_done | input | 1 | Status read completes |
| ser_sel | input | 1 | Serial mode select; high puts the request on ser_out |
| shift_bit | input | 1 | Current bit of the data shifter |
| ser_out | output | 1 | Shared serial data-out pin |
| irq_n | output | 1 | Active-low interrupt request |
| cause | output | 6 | Main latch contents, one bit per source |

## Verification
The critical overlap is an event that arrives in the same cycle as the clear or the close of a status read. A naive design either loses that event or lets it cancel the clear. Directed cases place strobes on the rd_start edge, on cycles in the middle of the read, and on the rd_done edge. They also cover a start and a done in the same cycle. A long random run then drives event strobes, wake and stop configuration, and read strobes independently of each other, so that these overlaps occur many times. After every edge, cause, irq_n and ser_out are compared with a reference model held in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_OPEN = 1'b1
  } rd_phase_t;

  // Cause vector layout: status bits first, then resume, bus reset, wake.
  function automatic int unsigned cause_width(input int unsigned nstat);
    return nstat + 3;
  endfunction

  function automatic int unsigned idx_resume(input int unsigned nstat);
    return nstat;
  endfunction

  function automatic int unsigned idx_bus_reset(input int unsigned nstat);
    return nstat + 1;
  endfunction

  function automatic int unsigned idx_wake(input int unsigned nstat);
    return nstat + 2;
  endfunction

  // Wake counts only in a stop state (any stop bit set).
  function automatic logic wake_allowed(input logic lvl, input logic any_stop);
    return lvl & any_stop;
  endfunction

endpackage

// File: rtl/irq_cause_gate.sv
module irq_cause_gate
  import irq_pkg::*;
#(
  parameter int unsigned NSTAT = 3,
  parameter int unsigned NSTOP = 2,
  localparam int unsigned NC = cause_width(NSTAT)
) (
  input  logic [NSTAT-1:0] ev_stat,
  input  logic             ev_resume,
  input  logic             ev_bus_reset,
  input  logic             wake_req,
  input  logic [NSTOP-1:0] stop_cfg,
  output logic [NC-1:0]    cause_now,
  output logic             wake_ok
);

  logic any_stop;
  assign any_stop = |stop_cfg;
  assign wake_ok  = wake_allowed(wake_req, any_stop);

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    assign cause_now[g] = ev_stat[g];
  end

  assign cause_now[idx_resume(NSTAT)]    = ev_resume;
  assign cause_now[idx_bus_reset(NSTAT)] = ev_bus_reset;
  assign cause_now[idx_wake(NSTAT)]      = wake_ok;

endmodule

// File: rtl/irq_read_track.sv
module irq_read_track
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic rd_done,
  output logic open_q,
  output logic in_read,
  output logic read_close
);

  rd_phase_t phase_q, phase_d;

  assign open_q     = (phase_q == PH_OPEN);
  assign in_read    = open_q | rd_start;
  assign read_close = in_read & rd_done;

  always_comb begin
    phase_d = phase_q;
    if (read_close)   phase_d = PH_IDLE;
    else if (in_read) phase_d = PH_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  AST_READ_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !rd_done) |=> open_q); // R10

  AST_CLOSE_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    read_close |=> !open_q); // R9

endmodule

// File: rtl/irq_two_stage.sv
module irq_two_stage #(
  parameter int unsigned NC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] cause_now,
  input  logic          open_q,
  input  logic          in_read,
  input  logic          read_close,
  output logic [NC-1:0] pend_q,
  output logic [NC-1:0] shadow_q
);

  logic [NC-1:0] shadow_base;
  logic [NC-1:0] pend_d, shadow_d;

  // A fresh read starts with an empty shadow; an open one keeps its contents.
  assign shadow_base = open_q ? shadow_q : '0;

  always_comb begin
    pend_d   = pend_q;
    shadow_d = shadow_q;
    if (read_close) begin
      pend_d   = shadow_base | cause_now;
      shadow_d = '0;
    end else if (in_read) begin
      pend_d   = '0;
      shadow_d = shadow_base | cause_now;
    end else begin
      pend_d   = pend_q | cause_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      shadow_q <= '0;
    end else begin
      pend_q   <= pend_d;
      shadow_q <= shadow_d;
    end
  end

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_read && (cause_now != '0)) |=> (pend_q != '0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_read && (pend_q != '0)) |=> (pend_q != '0)); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && !read_close) |=> (pend_q == '0)); // R5

  AST_DEFER_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (read_close && (shadow_base != '0)) |=> (pend_q != '0)); // R6

  AST_SHADOW_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
    read_close |=> (shadow_q == '0)); // R6

endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux #(
  parameter int unsigned NC = 6
) (
  input  logic [NC-1:0] pend_q,
  input  logic          ser_sel,
  input  logic          shift_bit,
  output logic          irq_n,
  output logic          ser_out
);

  assign irq_n   = ~(|pend_q);
  assign ser_out = ser_sel ? irq_n : shift_bit;

endmodule

// File: rtl/irq_latch_ctl.sv
module irq_latch_ctl
  import irq_pkg::*;
#(
  parameter int unsigned NSTAT = 3,
  parameter int unsigned NSTOP = 2,
  localparam int unsigned NC = cause_width(NSTAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] ev_stat,
  input  logic             ev_resume,
  input  logic             ev_bus_reset,
  input  logic             wake_req,
  input  logic [NSTOP-1:0] stop_cfg,
  input  logic             rd_start,
  input  logic             rd_done,
  input  logic             ser_sel,
  input  logic             shift_bit,
  output logic             ser_out,
  output logic             irq_n,
  output logic [NC-1:0]    cause
);

  logic [NC-1:0] cause_now;
  logic          wake_ok;
  logic          open_q, in_read, read_close;
  logic [NC-1:0] pend_q, shadow_q;

  irq_cause_gate #(.NSTAT(NSTAT), .NSTOP(NSTOP)) u_gate (
    .ev_stat      (ev_stat),
    .ev_resume    (ev_resume),
    .ev_bus_reset (ev_bus_reset),
    .wake_req     (wake_req),
    .stop_cfg     (stop_cfg),
    .cause_now    (cause_now),
    .wake_ok      (wake_ok)
  );

  irq_read_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_start   (rd_start),
    .rd_done    (rd_done),
    .open_q     (open_q),
    .in_read    (in_read),
    .read_close (read_close)
  );

  irq_two_stage #(.NC(NC)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .cause_now  (cause_now),
    .open_q     (open_q),
    .in_read    (in_read),
    .read_close (read_close),
    .pend_q     (pend_q),
    .shadow_q   (shadow_q)
  );

  irq_pin_mux #(.NC(NC)) u_mux (
    .pend_q    (pend_q),
    .ser_sel   (ser_sel),
    .shift_bit (shift_bit),
    .irq_n     (irq_n),
    .ser_out   (ser_out)
  );

  assign cause = pend_q;

  AST_WAKE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && (stop_cfg == '0) && !in_read && irq_n && !ev_resume
     && !ev_bus_reset && (ev_stat == '0)) |=> irq_n); // R4

  AST_WAKE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_ok && !in_read) |=> !irq_n); // R4

  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !in_read && (cause_now == '0)) |=> $stable(cause)); // R8

endmodule

// File: tb/tb_irq_latch_ctl.sv
module tb_irq_latch_ctl;

  localparam int NS = 3;
  localparam int NC = NS + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] ev_stat = '0;
  logic          ev_resume = 1'b0, ev_bus_reset = 1'b0, wake_req = 1'b0;
  logic [1:0]    stop_cfg = '0;
  logic          rd_start = 1'b0, rd_done = 1'b0;
  logic          ser_sel = 1'b0, shift_bit = 1'b0;
  logic          ser_out, irq_n;
  logic [NC-1:0] cause;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [NC-1:0] m_main = '0;
  logic [NC-1:0] m_held = '0;
  logic          m_open = 1'b0;

  always #2 clk = ~clk;

  irq_latch_ctl dut (
    .clk(clk), .rst_n(rst_n), .ev_stat(ev_stat), .ev_resume(ev_resume),
    .ev_bus_reset(ev_bus_reset), .wake_req(wake_req), .stop_cfg(stop_cfg),
    .rd_start(rd_start), .rd_done(rd_done), .ser_sel(ser_sel),
    .shift_bit(shift_bit), .ser_out(ser_out), .irq_n(irq_n), .cause(cause)
  );

  function automatic logic [NC-1:0] events_of(input logic [NS-1:0] s, input logic r,
      input logic b, input logic w, input logic [1:0] st);
    logic [NC-1:0] v;
    v = '0;
    v[NS-1:0] = s;
    v[NS]     = r;
    v[NS+1]   = b;
    v[NS+2]   = w && (st != 2'b00);
    return v;
  endfunction

  function automatic logic pin_expect(input logic sel, input logic sh, input logic [NC-1:0] m);
    if (sel) return (m == '0);
    return sh;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " cause"}, 32'(cause), 32'(m_main));
    check({tag, " irq_n"}, 32'(irq_n), 32'(m_main == '0));
    check({tag, " pin"},   32'(ser_out), 32'(pin_expect(ser_sel, shift_bit, m_main)));
  endtask

  // One clock: update the model with the inputs present at the edge.
  task automatic tick();
    logic [NC-1:0] ev;
    logic active, closing;
    @(posedge clk);
    ev = events_of(ev_stat, ev_resume, ev_bus_reset, wake_req, stop_cfg);
    active  = m_open || rd_start;
    closing = active && rd_done;
    if (closing) begin
      m_main = (m_open ? m_held : '0) | ev;
      m_held = '0;
      m_open = 1'b0;
    end else if (active) begin
      m_held = (m_open ? m_held : '0) | ev;
      m_main = '0;
      m_open = 1'b1;
    end else begin
      m_main = m_main | ev;
    end
    #1;
    @(negedge clk);
  endtask

  task automatic quiet();
    ev_stat = '0; ev_resume = 1'b0; ev_bus_reset = 1'b0;
    rd_start = 1'b0; rd_done = 1'b0;
  endtask

  task automatic full_read();
    rd_start = 1'b1; tick(); quiet();
    rd_done = 1'b1;  tick(); quiet();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    check("R1 cause zero", 32'(cause), 32'd0);

    // R2: each status strobe on its own
    for (int i = 0; i < NS; i++) begin
      ev_stat = NS'(1 << i); tick(); quiet();
      check("R2 stat bit", 32'(cause), 32'(1 << i));
      check("R2 irq low", 32'(irq_n), 32'd0);
      tick();
      check_all("R2 held");
      rd_start = 1'b1; tick(); quiet();
      check("R5 cleared on start", 32'(irq_n), 32'd1);
      tick();
      check("R5 stays clear", 32'(cause), 32'd0);
      rd_done = 1'b1; tick(); quiet();
      check_all("R5 after close");
    end

    // R3: resume and bus reset
    ev_resume = 1'b1; tick(); quiet();
    check("R3 resume", 32'(cause), 32'(1 << NS));
    full_read();
    ev_bus_reset = 1'b1; tick(); quiet();
    check("R3 bus reset", 32'(cause), 32'(1 << (NS + 1)));
    full_read();
    check_all("R3 cleared");

    // R4: wake gating by stop state
    wake_req = 1'b1; stop_cfg = 2'b00;
    repeat (3) tick();
    check("R4 wake ignored cause", 32'(cause), 32'd0);
    check("R4 wake ignored irq", 32'(irq_n), 32'd1);
    stop_cfg = 2'b01; tick();
    check("R4 wake stop0", 32'(cause), 32'(1 << (NS + 2)));
    wake_req = 1'b0; full_read();
    check("R4 cleared", 32'(cause), 32'd0);
    stop_cfg = 2'b10; wake_req = 1'b1; tick();
    check("R4 wake stop1", 32'(cause), 32'(1 << (NS + 2)));
    wake_req = 1'b0; stop_cfg = 2'b00; full_read();

    // R6: events on start edge, mid read and done edge are deferred
    rd_start = 1'b1; ev_stat = 3'b001; tick(); quiet();
    check("R6 start edge hidden", 32'(irq_n), 32'd1);
    ev_resume = 1'b1; tick(); quiet();
    check("R6 mid read hidden", 32'(irq_n), 32'd1);
    check("R6 mid cause", 32'(cause), 32'd0);
    rd_done = 1'b1; ev_stat = 3'b100; tick(); quiet();
    check("R6 released", 32'(cause), 32'b001101);
    check("R6 irq low", 32'(irq_n), 32'd0);
    full_read();
    check("R6 second read clears", 32'(cause), 32'd0);

    // R8: stray done ignored
    ev_stat = 3'b010; tick(); quiet();
    rd_done = 1'b1; tick(); quiet();
    check("R8 stray done", 32'(cause), 32'b000010);
    ev_bus_reset = 1'b1; rd_done = 1'b1; tick(); quiet();
    check("R8 accumulate", 32'(cause), 32'b010010);

    // R9: start and done together
    rd_start = 1'b1; rd_done = 1'b1; ev_stat = 3'b100; tick(); quiet();
    check("R9 same cycle", 32'(cause), 32'b000100);
    rd_start = 1'b1; rd_done = 1'b1; tick(); quiet();
    check("R9 empty read", 32'(cause), 32'd0);

    // R10: restart during open read keeps deferred events
    rd_start = 1'b1; tick(); quiet();
    ev_resume = 1'b1; tick(); quiet();
    rd_start = 1'b1; tick(); quiet();
    check("R10 still hidden", 32'(irq_n), 32'd1);
    rd_done = 1'b1; tick(); quiet();
    check("R10 kept", 32'(cause), 32'(1 << NS));
    full_read();

    // R7: pin select
    ser_sel = 1'b0; shift_bit = 1'b1; #1;
    check("R7 shifter one", 32'(ser_out), 32'd1);
    shift_bit = 1'b0; #1;
    check("R7 shifter zero", 32'(ser_out), 32'd0);
    ser_sel = 1'b1; shift_bit = 1'b1; #1;
    check("R7 irq idle high", 32'(ser_out), 32'd1);
    ev_stat = 3'b001; tick(); quiet();
    check("R7 irq on pin", 32'(ser_out), 32'd0);
    full_read();

    // Random mix, judged against the model (R6 overlaps dominate)
    for (int n = 0; n < 4000; n++) begin
      ev_stat      = ($urandom % 6 == 0) ? NS'($urandom) : '0;
      ev_resume    = ($urandom % 12 == 0);
      ev_bus_reset = ($urandom % 12 == 0);
      if ($urandom % 8 == 0) wake_req = $urandom;
      if ($urandom % 10 == 0) stop_cfg = 2'($urandom);
      rd_start     = ($urandom % 7 == 0);
      rd_done      = ($urandom % 5 == 0);
      ser_sel      = $urandom;
      shift_bit    = $urandom;
      tick();
      check_all("R6 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule